// File: doc/BRIEF.md
# Management-Bus Access Error Checker

This block sits beside the register file of a device that is managed over a two-wire management bus. It does not decode the serial frames itself; it watches each decoded register access (a 5-bit device address and a 5-bit register address forming a 10-bit absolute address, a direction flag, and the data moved) and owns two registers. One is a control register whose bit 0 arms the check. The other is a check register holding an 8-bit checksum and a mismatch status bit.

When the check is armed, the next access to any other register is a protected access. The block folds that access's data, its absolute address and its 2-bit opcode into an 8-bit checksum and latches it. The arm bit drops at that moment, so the host must arm again before each protected access. After a protected read, the host reads the check register and compares the checksum there against its own. After a protected write, the host writes its own checksum into the check register. The block compares it with the latched value and raises the mismatch bit if they differ. That bit stays set until the next protected access or reset.

Top module: `smi_err_checker`

## Requirements
- R1: After reset, reads of the check register (absolute address 0x339) and of the control register (0x33A) both return 0.
- R2: A write to 0x33A loads the arm bit from write data bit 0. A read of 0x33A returns the arm bit in bit 0 and zeros in all other bits.
- R3: The checksum bit i (i = 0..7) is the XOR of data bits i and i+8 and address bit i. Address bits 8 and 9 are also folded into checksum bits 0 and 1. Opcode bits 0 and 1 are also folded into checksum bits 2 and 3. The opcode is 2'b10 for a read and 2'b01 for a write.
- R4: After a protected read, a read of 0x339 returns the checksum of that read's data in bits 7:0.
- R5: After a protected write, a host write to 0x339 compares write data bits 7:0 with the latched checksum. Bit 8 of 0x339 reads 1 when they differ and 0 when they agree.
- R6: A protected access clears the arm bit. A read of 0x33A then returns 0.
- R7: An access while the arm bit is 0 leaves the latched checksum and the mismatch bit unchanged.
- R8: Accesses to 0x339 or 0x33A are never protected. They do not change the latched checksum and do not clear the arm bit.
- R9: The mismatch bit is sticky. It is cleared only by the next protected access or by reset.
- R10: A host write to 0x339 has no effect unless a protected write is awaiting its comparison. Only one comparison is made per protected write.
- R11: chk_hit is 1 exactly when the absolute address is 0x339 or 0x33A. chk_rdata is 0 for every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One-cycle strobe for a decoded register access |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| acc_phy | input | 5 | Device address field, the upper part of the absolute address |
| acc_reg | input | 5 | Register address field, the lower part of the absolute address |
| acc_wdata | input | 16 | Data the host writes |
| acc_rdata | input | 16 | Data the register file returns for a read of another register |
| chk_hit | output | 1 | The current address selects one of this block's registers |
| chk_rdata | output | 16 | Read data for this block's registers, 0 otherwise |

## Verification
The bench sweeps every absolute address through a protected read. A fold that dropped the address's top bits, or mixed in the wrong opcode, shows up as a wrong checksum at some address. Protected writes are followed by host checksums that are correct and then wrong in each single bit. A comparator that ignores a bit, or a flag that never rises, is caught there. The bench probes the arm bit after protected accesses and after accesses to the block's own registers. A design that keeps the arm bit set, or that latches a checksum for a read of the check register, gives the wrong readback. Stray host checksum writes, disarmed accesses and a second comparison for the same protected write are also tried. A flag that is not sticky, or that is re-evaluated when it should not be, changes bit 8 where it must hold.

// File: rtl/smi_chk_pkg.sv
package smi_chk_pkg;
   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/smi_csum_fold.sv
module smi_csum_fold #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10,
   parameter int CSUM_W = 8,
   parameter int OP_W   = 2
) (
   input  logic [DATA_W-1:0] data,
   input  logic [ADDR_W-1:0] addr,
   input  logic [OP_W-1:0]   op,
   output logic [CSUM_W-1:0] csum
);
   localparam int HI_W  = ADDR_W - CSUM_W;
   localparam int OP_LO = HI_W;

   if (DATA_W != 2 * CSUM_W) begin : g_bad_data
      $error("DATA_W must be twice CSUM_W");
   end
   if (HI_W < 0 || HI_W + OP_W > CSUM_W) begin : g_bad_addr
      $error("address overflow bits and opcode must fit in the checksum");
   end

   for (genvar i = 0; i < CSUM_W; i++) begin : g_bit
      logic base;
      assign base = data[i] ^ data[i+CSUM_W] ^ addr[i];
      if (i < HI_W) begin : g_hi
         assign csum[i] = base ^ addr[i+CSUM_W];
      end else if (i < OP_LO + OP_W) begin : g_op
         assign csum[i] = base ^ op[i-OP_LO];
      end else begin : g_plain
         assign csum[i] = base;
      end
   end
endmodule

// File: rtl/smi_chk_decode.sv
module smi_chk_decode #(
   parameter int          ADDR_W   = 10,
   parameter logic [9:0]  CHK_ADDR = 10'h339,
   parameter logic [9:0]  CTL_ADDR = 10'h33A
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              is_chk,
   output logic              is_ctl
);
   if (CHK_ADDR == CTL_ADDR) begin : g_bad_map
      $error("check and control registers must differ");
   end
   assign is_chk = (addr == ADDR_W'(CHK_ADDR));
   assign is_ctl = (addr == ADDR_W'(CTL_ADDR));
endmodule

// File: rtl/smi_err_checker.sv
module smi_err_checker #(
   parameter int         PHY_W    = 5,
   parameter int         REG_W    = 5,
   parameter int         DATA_W   = 16,
   parameter int         CSUM_W   = 8,
   parameter logic [9:0] CHK_ADDR = 10'h339,
   parameter logic [9:0] CTL_ADDR = 10'h33A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [PHY_W-1:0]  acc_phy,
   input  logic [REG_W-1:0]  acc_reg,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [DATA_W-1:0] acc_rdata,
   output logic              chk_hit,
   output logic [DATA_W-1:0] chk_rdata
);
   import smi_chk_pkg::*;
   localparam int ADDR_W = PHY_W + REG_W;
   localparam int PAD_W  = DATA_W - CSUM_W - 1;

   if (PAD_W < 0) begin : g_bad_width
      $error("data width too small for checksum and status");
   end

   logic [ADDR_W-1:0] addr;
   logic              is_chk, is_ctl, own, prot;
   logic [DATA_W-1:0] fold_data;
   logic [1:0]        fold_op;
   logic [CSUM_W-1:0] fold_csum;
   logic              en_q, mis_q, pend_q;
   logic [CSUM_W-1:0] csum_q;

   assign addr = {acc_phy, acc_reg};

   smi_chk_decode #(.ADDR_W(ADDR_W), .CHK_ADDR(CHK_ADDR), .CTL_ADDR(CTL_ADDR)) u_dec (
      .addr(addr), .is_chk(is_chk), .is_ctl(is_ctl));

   assign own       = is_chk | is_ctl;
   assign prot      = acc_valid & en_q & ~own;
   assign fold_data = acc_write ? acc_wdata : acc_rdata;
   assign fold_op   = acc_write ? OP_WR : OP_RD;

   smi_csum_fold #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CSUM_W(CSUM_W), .OP_W(2)) u_fold (
      .data(fold_data), .addr(addr), .op(fold_op), .csum(fold_csum));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mis_q  <= 1'b0;
         pend_q <= 1'b0;
         csum_q <= '0;
      end else if (prot) begin
         csum_q <= fold_csum;
         mis_q  <= 1'b0;
         pend_q <= acc_write;
         en_q   <= 1'b0;
      end else if (acc_valid && acc_write && is_ctl) begin
         en_q <= acc_wdata[0];
      end else if (acc_valid && acc_write && is_chk && pend_q) begin
         mis_q  <= (acc_wdata[CSUM_W-1:0] != csum_q);
         pend_q <= 1'b0;
      end
   end

   assign chk_hit = own;

   always_comb begin
      chk_rdata = '0;
      if (is_chk)      chk_rdata = {{PAD_W{1'b0}}, mis_q, csum_q};
      else if (is_ctl) chk_rdata = {{(DATA_W-1){1'b0}}, en_q};
   end
endmodule

// File: rtl/smi_err_checker_sva.sv
module smi_err_checker_sva #(
   parameter int         PHY_W    = 5,
   parameter int         REG_W    = 5,
   parameter int         DATA_W   = 16,
   parameter int         CSUM_W   = 8,
   parameter logic [9:0] CHK_ADDR = 10'h339,
   parameter logic [9:0] CTL_ADDR = 10'h33A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [PHY_W-1:0]  acc_phy,
   input logic [REG_W-1:0]  acc_reg,
   input logic [DATA_W-1:0] acc_wdata,
   input logic              chk_hit,
   input logic [DATA_W-1:0] chk_rdata,
   input logic              en_q,
   input logic              mis_q,
   input logic              pend_q,
   input logic [CSUM_W-1:0] csum_q
);
   localparam int ADDR_W = PHY_W + REG_W;
   logic [ADDR_W-1:0] a;
   logic at_chk, at_ctl, guarded;
   assign a       = {acc_phy, acc_reg};
   assign at_chk  = (a == ADDR_W'(CHK_ADDR));
   assign at_ctl  = (a == ADDR_W'(CTL_ADDR));
   assign guarded = acc_valid && en_q && !at_chk && !at_ctl;

   p_ctl_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      at_ctl |-> (chk_rdata[DATA_W-1:1] == '0));
   p_en_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      guarded |=> !en_q);
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !en_q && !at_chk && !at_ctl) |=> ($stable(csum_q) && $stable(mis_q)));
   p_own_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (at_chk || at_ctl)) |=> $stable(csum_q));
   p_mis_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      guarded |=> !mis_q);
   p_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && at_chk && !pend_q) |=> $stable(mis_q));
   p_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      chk_hit == (at_chk || at_ctl));
endmodule

bind smi_err_checker smi_err_checker_sva #(
   .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .CSUM_W(CSUM_W),
   .CHK_ADDR(CHK_ADDR), .CTL_ADDR(CTL_ADDR)
) u_sva (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_phy(acc_phy), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
   .chk_hit(chk_hit), .chk_rdata(chk_rdata), .en_q(en_q), .mis_q(mis_q),
   .pend_q(pend_q), .csum_q(csum_q)
);

// File: tb/tb_smi_err_checker.sv
module tb_smi_err_checker;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        acc_valid = 0, acc_write = 0;
   logic [4:0]  acc_phy = 0, acc_reg = 0;
   logic [15:0] acc_wdata = 0, acc_rdata = 0;
   logic        chk_hit;
   logic [15:0] chk_rdata;
   int checks = 0, errors = 0;
   bit done = 0;

   localparam logic [9:0] A_CHK = 10'h339;
   localparam logic [9:0] A_CTL = 10'h33A;

   smi_err_checker dut (.*);

   always #2 clk = ~clk;

   function automatic logic [7:0] ref_csum(logic [15:0] d, logic [9:0] a, logic wr);
      logic [1:0] op = wr ? 2'b01 : 2'b10;
      logic [7:0] c;
      for (int i = 0; i < 8; i++) begin
         c[i] = d[i] ^ d[i+8] ^ a[i];
         if (i < 2) c[i] = c[i] ^ a[i+8];
         else if (i < 4) c[i] = c[i] ^ op[i-2];
      end
      return c;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(logic wr, logic [9:0] a, logic [15:0] wd, logic [15:0] rd,
                      output logic [15:0] q, output logic hit);
      @(negedge clk);
      acc_valid = 1; acc_write = wr; {acc_phy, acc_reg} = a;
      acc_wdata = wd; acc_rdata = rd;
      #1 q = chk_rdata; hit = chk_hit;
      @(negedge clk);
      acc_valid = 0;
   endtask

   logic [15:0] q;
   logic        h;

   task automatic arm();
      acc(1, A_CTL, 16'h0001, 0, q, h);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] c;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      acc(0, A_CHK, 0, 16'hFFFF, q, h); check("R1 chk", q, 0);
      check("R11 hit chk", h, 1);
      acc(0, A_CTL, 0, 16'hFFFF, q, h); check("R1 ctl", q, 0);
      check("R11 hit ctl", h, 1);
      // R2 arm bit load and readback
      acc(1, A_CTL, 16'hFFFF, 0, q, h);
      acc(0, A_CTL, 0, 0, q, h); check("R2 set", q, 1);
      acc(1, A_CTL, 16'hFFFE, 0, q, h);
      acc(0, A_CTL, 0, 0, q, h); check("R2 clr", q, 0);
      // R3 R4 R6 R11 protected read sweep over every address
      for (int a = 0; a < 1024; a++) begin
         logic [15:0] d = 16'((a * 40503 + 16'h1234) ^ (a << 6));
         if (a == A_CHK || a == A_CTL) continue;
         arm();
         acc(0, 10'(a), 16'hA5A5, d, q, h);
         check("R11 no hit", {h, q}, 0);
         acc(0, A_CHK, 0, 0, q, h);
         check("R3 R4 read csum", q, {8'h00, ref_csum(d, 10'(a), 0)});
         if (a % 64 == 5) begin
            acc(0, A_CTL, 0, 0, q, h); check("R6 arm dropped", q, 0);
         end
      end
      // R5 protected writes: correct then each single-bit-wrong checksum
      for (int k = 0; k < 9; k++) begin
         logic [9:0]  a = 10'(37 * k + 300);
         logic [15:0] d = 16'(16'hC3E1 ^ (k * 4099));
         c = ref_csum(d, a, 1);
         arm();
         acc(1, a, d, 0, q, h);
         acc(1, A_CHK, k == 8 ? {8'h00, c} : {8'h00, c ^ 8'(1 << k)}, 0, q, h);
         acc(0, A_CHK, 0, 0, q, h);
         check("R3 R5 write compare", q, {7'd0, k != 8, c});
      end
      // R9 sticky flag: set it, survive disarmed and own accesses, clear by protected
      c = ref_csum(16'h0F0F, 10'h055, 1);
      arm(); acc(1, 10'h055, 16'h0F0F, 0, q, h);
      acc(1, A_CHK, {8'h00, ~c}, 0, q, h);
      acc(0, 10'h120, 0, 16'h7777, q, h);
      acc(1, 10'h121, 16'h1111, 0, q, h);
      acc(0, A_CHK, 0, 0, q, h); check("R7 R9 sticky", q, {7'd0, 1'b1, c});
      // R10 second comparison for the same write is ignored
      acc(1, A_CHK, {8'h00, c}, 0, q, h);
      acc(0, A_CHK, 0, 0, q, h); check("R10 one compare", q, {7'd0, 1'b1, c});
      arm(); acc(0, 10'h2AA, 0, 16'hBEEF, q, h);
      acc(0, A_CHK, 0, 0, q, h);
      check("R9 cleared", q, {8'h00, ref_csum(16'hBEEF, 10'h2AA, 0)});
      // R10 host checksum after a protected read is ignored
      acc(1, A_CHK, 16'h00FF ^ {8'h00, ref_csum(16'hBEEF, 10'h2AA, 0)}, 0, q, h);
      acc(0, A_CHK, 0, 0, q, h);
      check("R10 after read", q, {8'h00, ref_csum(16'hBEEF, 10'h2AA, 0)});
      // R8 own-register accesses while armed are not protected
      arm();
      acc(0, A_CHK, 0, 16'h4321, q, h);
      acc(1, A_CHK, 16'h00FF, 0, q, h);
      acc(0, A_CTL, 0, 0, q, h); check("R8 arm kept", q, 1);
      acc(0, A_CHK, 0, 0, q, h);
      check("R8 csum kept", q, {8'h00, ref_csum(16'hBEEF, 10'h2AA, 0)});
      // R7 disarmed accesses leave checksum unchanged
      acc(1, A_CTL, 0, 0, q, h);
      acc(0, 10'h001, 0, 16'hFFFF, q, h);
      acc(0, A_CHK, 0, 0, q, h);
      check("R7 hold", q, {8'h00, ref_csum(16'hBEEF, 10'h2AA, 0)});
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule